// File: doc/BRIEF.md
# DMA Channel Command and Status Controller

This block is the control front end of one memory-to-memory DMA channel. Software writes one-hot command words into a command register to enable, clear, disable, stop, pause or resume the channel. The block keeps the channel state, which is one of idle, running, paused, stopped, done or error. It issues single-cycle start, pause, resume and abort strobes to the transfer datapath, and it takes in the datapath's completion and error pulses.

A status word reports the channel state and two sticky interrupt flags, one for completion and one for error. Software clears these flags by writing ones to them. An enable register masks each flag onto a level interrupt output. When the datapath reports an error, an error-cause register records which kinds of bus fault it saw.

Registers sit at byte offsets 0x0 (command, reads as zero), 0x4 (status), 0x8 (interrupt enable) and 0xC (error cause). Writes take effect at the clock edge on which `reg_wr_i` is high. Reads are combinational on `reg_raddr_i`.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset, the status word reads only the idle flag (bit18). The enable register and the error-cause register read zero, `irq_o` is low and all strobes are low.
- R2: An ENABLE command (command bit0) in the idle, stopped, done or error state moves the channel to running (status reads no state flag). `xfer_start_o` pulses for the one cycle that follows the write. ENABLE has no effect while the channel is running or paused.
- R3: PAUSE (bit4) acts only when the channel is running. It moves the channel to paused (status bit20) and pulses `xfer_pause_o`. RESUME (bit5) acts only when the channel is paused. It returns the channel to running and pulses `xfer_resume_o`. In every other state both commands have no effect.
- R4: STOP (bit3) moves the channel to stopped (status bit19) from any state. It pulses `xfer_abort_o` only when the channel was running or paused.
- R5: DISABLE (bit2) while running or paused returns the channel to idle and pulses `xfer_abort_o`. In any other state it has no effect.
- R6: When one write sets several command bits, only the highest-priority bit takes part: STOP, then DISABLE, then PAUSE, then RESUME, then ENABLE, then CLEAR. A highest bit that does not apply in the current state means the write has no effect.
- R7: CLEAR (bit1) outside running and paused returns the channel to idle and zeroes both interrupt flags and the error-cause register. CLEAR has no effect while the channel is running or paused.
- R8: While the channel is running or paused, a `xfer_done_i` pulse moves it to done (status bit16) and sets the done flag (bit0). A `xfer_err_i` pulse moves it to error (bit17) and sets the error flag (bit1). Error wins when both pulses arrive together. A STOP or DISABLE written in the same cycle beats either pulse. PAUSE and RESUME lose to them. In every other state these pulses are ignored.
- R9: An accepted error loads the error-cause register from `xfer_err_cause_i`: read-response fault at bit16, write-response fault at bit17, read-data poison at bit18.
- R10: Writing ones to status bit0 or bit1 clears the matching flag, and the state flags are left unchanged. A flag that is being set in the same cycle stays set.
- R11: `irq_o` is high exactly when (done flag AND enable bit0) OR (error flag AND enable bit1). The enable bits read back at offset 0x8, bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Write byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_raddr_i | input | ADDR_W | Read byte address |
| reg_rdata_o | output | 32 | Read data (combinational) |
| xfer_start_o | output | 1 | Start strobe to datapath |
| xfer_pause_o | output | 1 | Pause strobe to datapath |
| xfer_resume_o | output | 1 | Resume strobe to datapath |
| xfer_abort_o | output | 1 | Abort strobe to datapath |
| xfer_done_i | input | 1 | Transfer completion pulse |
| xfer_err_i | input | 1 | Transfer error pulse |
| xfer_err_cause_i | input | 3 | Fault kinds: bit0 read response, bit1 write response, bit2 poison |
| irq_o | output | 1 | Level interrupt |

## Verification
The command register is exercised in three ways. Single one-hot writes are issued in every state, which separates state-qualified commands from commands that apply anywhere. A write with all command bits set shows whether the priority order holds. Commands that do not apply in the current state, such as CLEAR while running and PAUSE while idle, show whether they are truly ignored. Datapath pulses are sent alone, together, and in the same cycle as a STOP or a status-clear write, which tests how events are ordered against commands. Masking patterns on the enable register separate the two interrupt paths.

// File: rtl/dma_chan_ctl_pkg.sv
package dma_chan_ctl_pkg;

   typedef enum logic [2:0] {
      CH_IDLE    = 3'd0,
      CH_RUN     = 3'd1,
      CH_PAUSED  = 3'd2,
      CH_STOPPED = 3'd3,
      CH_DONE    = 3'd4,
      CH_ERROR   = 3'd5
   } ch_state_e;

   typedef enum logic [2:0] {
      ACT_NONE    = 3'd0,
      ACT_STOP    = 3'd1,
      ACT_DISABLE = 3'd2,
      ACT_PAUSE   = 3'd3,
      ACT_RESUME  = 3'd4,
      ACT_ENABLE  = 3'd5,
      ACT_CLEAR   = 3'd6
   } ch_act_e;

   localparam int DATA_W       = 32;
   localparam int CMD_W        = 6;
   localparam int CAUSE_W      = 3;

   localparam int OFF_CMD      = 'h0;
   localparam int OFF_STAT     = 'h4;
   localparam int OFF_IEN      = 'h8;
   localparam int OFF_CAUSE    = 'hC;

   localparam int CB_ENABLE    = 0;
   localparam int CB_CLEAR     = 1;
   localparam int CB_DISABLE   = 2;
   localparam int CB_STOP      = 3;
   localparam int CB_PAUSE     = 4;
   localparam int CB_RESUME    = 5;

   localparam int SB_DONE      = 16;
   localparam int SB_ERR       = 17;
   localparam int SB_IDLE      = 18;
   localparam int SB_STOPPED   = 19;
   localparam int SB_PAUSED    = 20;
   localparam int CAUSE_LSB    = 16;

endpackage

// File: rtl/dma_chan_ctl_decode.sv
module dma_chan_ctl_decode
   import dma_chan_ctl_pkg::*;
(
   input  logic             cmd_wr_i,
   input  logic [CMD_W-1:0] cmd_bits_i,
   output ch_act_e          act_o
);

   always_comb begin
      act_o = ACT_NONE;
      if (cmd_wr_i) begin
         if      (cmd_bits_i[CB_STOP])    act_o = ACT_STOP;
         else if (cmd_bits_i[CB_DISABLE]) act_o = ACT_DISABLE;
         else if (cmd_bits_i[CB_PAUSE])   act_o = ACT_PAUSE;
         else if (cmd_bits_i[CB_RESUME])  act_o = ACT_RESUME;
         else if (cmd_bits_i[CB_ENABLE])  act_o = ACT_ENABLE;
         else if (cmd_bits_i[CB_CLEAR])   act_o = ACT_CLEAR;
      end
   end

endmodule

// File: rtl/dma_chan_ctl_fsm.sv
module dma_chan_ctl_fsm
   import dma_chan_ctl_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  ch_act_e   act_i,
   input  logic      dp_done_i,
   input  logic      dp_err_i,
   output ch_state_e state_o,
   output logic      acc_done_o,
   output logic      acc_err_o,
   output logic      acc_clr_o,
   output logic      start_o,
   output logic      pause_o,
   output logic      resume_o,
   output logic      abort_o
);

   ch_state_e st_q, st_d;
   logic      go_start, go_pause, go_resume, go_abort;
   logic      active;

   assign active = (st_q == CH_RUN) || (st_q == CH_PAUSED);

   always_comb begin
      st_d       = st_q;
      go_start   = 1'b0;
      go_pause   = 1'b0;
      go_resume  = 1'b0;
      go_abort   = 1'b0;
      acc_done_o = 1'b0;
      acc_err_o  = 1'b0;
      acc_clr_o  = 1'b0;
      if (active) begin
         if (act_i == ACT_STOP) begin
            st_d = CH_STOPPED;  go_abort = 1'b1;
         end else if (act_i == ACT_DISABLE) begin
            st_d = CH_IDLE;     go_abort = 1'b1;
         end else if (dp_err_i) begin
            st_d = CH_ERROR;    acc_err_o = 1'b1;
         end else if (dp_done_i) begin
            st_d = CH_DONE;     acc_done_o = 1'b1;
         end else if (act_i == ACT_PAUSE && st_q == CH_RUN) begin
            st_d = CH_PAUSED;   go_pause = 1'b1;
         end else if (act_i == ACT_RESUME && st_q == CH_PAUSED) begin
            st_d = CH_RUN;      go_resume = 1'b1;
         end
      end else begin
         unique case (act_i)
            ACT_STOP:   st_d = CH_STOPPED;
            ACT_ENABLE: begin st_d = CH_RUN;  go_start = 1'b1;  end
            ACT_CLEAR:  begin st_d = CH_IDLE; acc_clr_o = 1'b1; end
            default:    st_d = st_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= CH_IDLE;
         start_o  <= 1'b0;
         pause_o  <= 1'b0;
         resume_o <= 1'b0;
         abort_o  <= 1'b0;
      end else begin
         st_q     <= st_d;
         start_o  <= go_start;
         pause_o  <= go_pause;
         resume_o <= go_resume;
         abort_o  <= go_abort;
      end
   end

   assign state_o = st_q;

endmodule

// File: rtl/dma_chan_ctl_flags.sv
module dma_chan_ctl_flags
   import dma_chan_ctl_pkg::*;
#(
   parameter bit IRQ_REG = 1'b0
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               acc_done_i,
   input  logic               acc_err_i,
   input  logic               acc_clr_i,
   input  logic [CAUSE_W-1:0] cause_i,
   input  logic               w1c_wr_i,
   input  logic [1:0]         w1c_bits_i,
   input  logic               ien_wr_i,
   input  logic [1:0]         ien_bits_i,
   output logic               intr_done_o,
   output logic               intr_err_o,
   output logic [CAUSE_W-1:0] cause_o,
   output logic [1:0]         ien_o,
   output logic               irq_o
);

   logic               done_q, err_q;
   logic [CAUSE_W-1:0] cause_q;
   logic [1:0]         ien_q;
   logic               irq_raw;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         cause_q <= '0;
         ien_q   <= 2'b00;
      end else begin
         if (acc_clr_i)                      done_q <= 1'b0;
         else if (acc_done_i)                done_q <= 1'b1;
         else if (w1c_wr_i && w1c_bits_i[0]) done_q <= 1'b0;

         if (acc_clr_i)                      err_q <= 1'b0;
         else if (acc_err_i)                 err_q <= 1'b1;
         else if (w1c_wr_i && w1c_bits_i[1]) err_q <= 1'b0;

         if (acc_clr_i)      cause_q <= '0;
         else if (acc_err_i) cause_q <= cause_i;

         if (ien_wr_i) ien_q <= ien_bits_i;
      end
   end

   assign irq_raw = (done_q & ien_q[0]) | (err_q & ien_q[1]);

   generate
      if (IRQ_REG) begin : g_irq_flop
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_raw;
         end
         assign irq_o = irq_q;
      end else begin : g_irq_comb
         assign irq_o = irq_raw;
      end
   endgenerate

   assign intr_done_o = done_q;
   assign intr_err_o  = err_q;
   assign cause_o     = cause_q;
   assign ien_o       = ien_q;

endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
   import dma_chan_ctl_pkg::*;
#(
   parameter int ADDR_W  = 4,
   parameter bit IRQ_REG = 1'b0
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr_i,
   input  logic [ADDR_W-1:0]    reg_addr_i,
   input  logic [DATA_W-1:0]    reg_wdata_i,
   input  logic [ADDR_W-1:0]    reg_raddr_i,
   output logic [DATA_W-1:0]    reg_rdata_o,
   output logic                 xfer_start_o,
   output logic                 xfer_pause_o,
   output logic                 xfer_resume_o,
   output logic                 xfer_abort_o,
   input  logic                 xfer_done_i,
   input  logic                 xfer_err_i,
   input  logic [CAUSE_W-1:0]   xfer_err_cause_i,
   output logic                 irq_o
);

   localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(OFF_CMD);
   localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFF_STAT);
   localparam logic [ADDR_W-1:0] A_IEN   = ADDR_W'(OFF_IEN);
   localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(OFF_CAUSE);

   generate
      if (ADDR_W < 4) begin : g_bad_addr_w
         $error("dma_chan_ctl: ADDR_W must be at least 4");
      end
   endgenerate

   ch_act_e            act;
   ch_state_e          st_q;
   logic               acc_done, acc_err, acc_clr;
   logic               intr_done, intr_err;
   logic [CAUSE_W-1:0] cause;
   logic [1:0]         ien;
   logic               cmd_wr, stat_wr, ien_wr;

   assign cmd_wr  = reg_wr_i && (reg_addr_i == A_CMD);
   assign stat_wr = reg_wr_i && (reg_addr_i == A_STAT);
   assign ien_wr  = reg_wr_i && (reg_addr_i == A_IEN);

   dma_chan_ctl_decode u_dec (
      .cmd_wr_i   (cmd_wr),
      .cmd_bits_i (reg_wdata_i[CMD_W-1:0]),
      .act_o      (act)
   );

   dma_chan_ctl_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .act_i      (act),
      .dp_done_i  (xfer_done_i),
      .dp_err_i   (xfer_err_i),
      .state_o    (st_q),
      .acc_done_o (acc_done),
      .acc_err_o  (acc_err),
      .acc_clr_o  (acc_clr),
      .start_o    (xfer_start_o),
      .pause_o    (xfer_pause_o),
      .resume_o   (xfer_resume_o),
      .abort_o    (xfer_abort_o)
   );

   dma_chan_ctl_flags #(.IRQ_REG(IRQ_REG)) u_flags (
      .clk         (clk),
      .rst_n       (rst_n),
      .acc_done_i  (acc_done),
      .acc_err_i   (acc_err),
      .acc_clr_i   (acc_clr),
      .cause_i     (xfer_err_cause_i),
      .w1c_wr_i    (stat_wr),
      .w1c_bits_i  (reg_wdata_i[1:0]),
      .ien_wr_i    (ien_wr),
      .ien_bits_i  (reg_wdata_i[1:0]),
      .intr_done_o (intr_done),
      .intr_err_o  (intr_err),
      .cause_o     (cause),
      .ien_o       (ien),
      .irq_o       (irq_o)
   );

   logic unused_wdata;
   assign unused_wdata = ^reg_wdata_i[DATA_W-1:CMD_W];

   always_comb begin
      reg_rdata_o = '0;
      unique case (reg_raddr_i)
         A_STAT: begin
            reg_rdata_o[0]          = intr_done;
            reg_rdata_o[1]          = intr_err;
            reg_rdata_o[SB_DONE]    = (st_q == CH_DONE);
            reg_rdata_o[SB_ERR]     = (st_q == CH_ERROR);
            reg_rdata_o[SB_IDLE]    = (st_q == CH_IDLE);
            reg_rdata_o[SB_STOPPED] = (st_q == CH_STOPPED);
            reg_rdata_o[SB_PAUSED]  = (st_q == CH_PAUSED);
         end
         A_IEN:   reg_rdata_o[1:0] = ien;
         A_CAUSE: reg_rdata_o[CAUSE_LSB +: CAUSE_W] = cause;
         default: reg_rdata_o = '0;
      endcase
   end

endmodule

// File: rtl/dma_chan_ctl_chk.sv
module dma_chan_ctl_chk
   import dma_chan_ctl_pkg::*;
#(
   parameter int ADDR_W = 4
)(
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr_i,
   input logic [ADDR_W-1:0] reg_addr_i,
   input logic [DATA_W-1:0] reg_wdata_i,
   input logic              xfer_start_o,
   input logic              xfer_pause_o,
   input logic              xfer_resume_o,
   input logic              xfer_abort_o,
   input logic              xfer_done_i,
   input logic              xfer_err_i,
   input logic [2:0]        st_q,
   input logic              intr_done,
   input logic              intr_err
);

   // R3: at most one datapath strobe per cycle
   a_r3_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({xfer_start_o, xfer_pause_o, xfer_resume_o, xfer_abort_o}));

   a_r2_start_in_run: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start_o |-> (st_q == CH_RUN));

   a_r3_pause_in_paused: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_pause_o |-> (st_q == CH_PAUSED));

   a_r3_resume_in_run: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_resume_o |-> (st_q == CH_RUN));

   a_r4_abort_leaves_active: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_abort_o |-> (st_q == CH_STOPPED || st_q == CH_IDLE));

   a_r8_done_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done_i && !xfer_err_i && !reg_wr_i && st_q == CH_RUN) |=> intr_done);

   a_r7_clear_idles: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_i && reg_addr_i == ADDR_W'(OFF_CMD) && reg_wdata_i[CMD_W-1:0] == 6'b000010
       && st_q != CH_RUN && st_q != CH_PAUSED)
      |=> (st_q == CH_IDLE && !intr_done && !intr_err));

endmodule

bind dma_chan_ctl dma_chan_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .reg_wr_i      (reg_wr_i),
   .reg_addr_i    (reg_addr_i),
   .reg_wdata_i   (reg_wdata_i),
   .xfer_start_o  (xfer_start_o),
   .xfer_pause_o  (xfer_pause_o),
   .xfer_resume_o (xfer_resume_o),
   .xfer_abort_o  (xfer_abort_o),
   .xfer_done_i   (xfer_done_i),
   .xfer_err_i    (xfer_err_i),
   .st_q          (st_q),
   .intr_done     (intr_done),
   .intr_err      (intr_err)
);

// File: tb/dma_chan_ctl_bench.sv
module dma_chan_ctl_bench;

   localparam int CLK_NS = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [3:0]  reg_raddr = 4'h4;
   logic [31:0] reg_rdata;
   logic        st_o, pa_o, re_o, ab_o;
   logic        done_p = 1'b0, err_p = 1'b0;
   logic [2:0]  cause = '0;
   logic        irq;

   int errors = 0;
   int checks = 0;
   bit hold = 1'b0;
   bit finished = 1'b0;

   always #(CLK_NS/2) clk = ~clk;

   dma_chan_ctl u_dma_chan_ctl (
      .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
      .reg_wdata_i(reg_wdata), .reg_raddr_i(reg_raddr), .reg_rdata_o(reg_rdata),
      .xfer_start_o(st_o), .xfer_pause_o(pa_o), .xfer_resume_o(re_o),
      .xfer_abort_o(ab_o), .xfer_done_i(done_p), .xfer_err_i(err_p),
      .xfer_err_cause_i(cause), .irq_o(irq));

   // reference model: states 0 idle,1 run,2 paused,3 stopped,4 done,5 error
   int      m_st;
   bit      m_fd, m_fe;
   bit [2:0] m_cause;
   bit [1:0] m_ien;
   bit      m_start, m_pause, m_resume, m_abort;

   function automatic logic [31:0] m_read(input logic [3:0] a);
      logic [31:0] v = '0;
      if (a == 4'h4) begin
         v[0] = m_fd; v[1] = m_fe;
         v[16] = (m_st == 4); v[17] = (m_st == 5); v[18] = (m_st == 0);
         v[19] = (m_st == 3); v[20] = (m_st == 2);
      end else if (a == 4'h8) v[1:0] = m_ien;
      else if (a == 4'hC) v[18:16] = m_cause;
      return v;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_fd = 0; m_fe = 0; m_cause = 0; m_ien = 0;
         m_start = 0; m_pause = 0; m_resume = 0; m_abort = 0;
      end else begin
         string cmd;
         bit busy, sd, se, clr;
         m_start = 0; m_pause = 0; m_resume = 0; m_abort = 0;
         sd = 0; se = 0; clr = 0;
         cmd = "";
         if (reg_wr && reg_addr == 4'h0) begin
            if (reg_wdata[3]) cmd = "stop";
            else if (reg_wdata[2]) cmd = "disable";
            else if (reg_wdata[4]) cmd = "pause";
            else if (reg_wdata[5]) cmd = "resume";
            else if (reg_wdata[0]) cmd = "enable";
            else if (reg_wdata[1]) cmd = "clear";
         end
         busy = (m_st == 1 || m_st == 2);
         if (busy) begin
            if (cmd == "stop") begin m_st = 3; m_abort = 1; end
            else if (cmd == "disable") begin m_st = 0; m_abort = 1; end
            else if (err_p) begin m_st = 5; se = 1; end
            else if (done_p) begin m_st = 4; sd = 1; end
            else if (cmd == "pause" && m_st == 1) begin m_st = 2; m_pause = 1; end
            else if (cmd == "resume" && m_st == 2) begin m_st = 1; m_resume = 1; end
         end else begin
            if (cmd == "stop") m_st = 3;
            else if (cmd == "enable") begin m_st = 1; m_start = 1; end
            else if (cmd == "clear") begin m_st = 0; clr = 1; end
         end
         if (reg_wr && reg_addr == 4'h4) begin
            if (reg_wdata[0]) m_fd = 0;
            if (reg_wdata[1]) m_fe = 0;
         end
         if (sd) m_fd = 1;
         if (se) begin m_fe = 1; m_cause = cause; end
         if (clr) begin m_fd = 0; m_fe = 0; m_cause = 0; end
         if (reg_wr && reg_addr == 4'h8) m_ien = reg_wdata[1:0];
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // cycle compare against the model
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         string t;
         case (reg_raddr)
            4'h4: t = "R8 status";
            4'h8: t = "R11 enable";
            4'hC: t = "R9 cause";
            default: t = "R1 command-read";
         endcase
         chk(t, reg_rdata, m_read(reg_raddr));
         chk("R2 start", {31'd0, st_o}, {31'd0, m_start});
         chk("R3 pause", {31'd0, pa_o}, {31'd0, m_pause});
         chk("R3 resume", {31'd0, re_o}, {31'd0, m_resume});
         chk("R4 abort", {31'd0, ab_o}, {31'd0, m_abort});
         chk("R11 irq", {31'd0, irq},
             {31'd0, (m_fd & m_ien[0]) | (m_fe & m_ien[1])});
      end
   end

   // rotate the read address when not held
   always @(posedge clk) begin
      #3;
      if (!hold) reg_raddr = reg_raddr + 4'h4;
   end

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(posedge clk); #2;
      reg_wr = 1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #2;
      reg_wr = 0; reg_wdata = 0;
   endtask

   task automatic dp(input bit d, input bit e, input logic [2:0] c);
      @(posedge clk); #2;
      done_p = d; err_p = e; cause = c;
      @(posedge clk); #2;
      done_p = 0; err_p = 0; cause = 0;
   endtask

   task automatic look(input string tag, input logic [3:0] a, input logic [31:0] exp);
      hold = 1; reg_raddr = a;
      @(negedge clk);
      chk(tag, reg_rdata, exp);
      hold = 0;
   endtask

   initial begin
      #(CLK_NS * 200000);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1;
      look("R1 reset status", 4'h4, 32'h0004_0000);
      look("R1 reset enable", 4'h8, 32'h0);
      look("R1 reset cause", 4'hC, 32'h0);
      wr(4'h8, 32'h3);
      wr(4'h0, 32'h01);                       // enable
      look("R2 running", 4'h4, 32'h0);
      wr(4'h0, 32'h01);                       // enable while running: no effect
      wr(4'h0, 32'h10);                       // pause
      look("R3 paused", 4'h4, 32'h0010_0000);
      wr(4'h0, 32'h10);                       // pause while paused: no effect
      wr(4'h0, 32'h20);                       // resume
      look("R3 resumed", 4'h4, 32'h0);
      dp(1, 0, 3'b000);
      look("R8 done", 4'h4, 32'h0001_0001);
      wr(4'h4, 32'h1);
      look("R10 w1c done", 4'h4, 32'h0001_0000);
      wr(4'h0, 32'h02);
      look("R7 clear idle", 4'h4, 32'h0004_0000);
      wr(4'h0, 32'h10);                       // pause in idle: ignored
      look("R3 pause ignored", 4'h4, 32'h0004_0000);
      wr(4'h0, 32'h01);
      wr(4'h0, 32'h3F);                       // all bits: stop wins
      look("R6 priority stop", 4'h4, 32'h0008_0000);
      wr(4'h0, 32'h01);
      wr(4'h0, 32'h02);                       // clear while running: ignored
      look("R7 clear ignored", 4'h4, 32'h0);
      dp(0, 1, 3'b100);
      look("R8 error", 4'h4, 32'h0002_0002);
      look("R9 poison", 4'hC, 32'h0004_0000);
      wr(4'h8, 32'h1);
      look("R11 err masked", 4'h8, 32'h1);
      wr(4'h0, 32'h02);
      look("R7 clear cause", 4'hC, 32'h0);
      wr(4'h0, 32'h01);
      dp(1, 1, 3'b010);                       // both pulses: error wins
      look("R8 err beats done", 4'h4, 32'h0002_0002);
      look("R9 write fault", 4'hC, 32'h0002_0000);
      wr(4'h0, 32'h01);
      wr(4'h0, 32'h14);                       // disable beats pause
      look("R5 disable", 4'h4, 32'h0004_0002);
      wr(4'h0, 32'h04);                       // disable in idle: no effect
      look("R5 disable idle", 4'h4, 32'h0004_0002);
      wr(4'h0, 32'h08);                       // stop from idle
      look("R4 stop idle", 4'h4, 32'h0008_0002);
      dp(1, 0, 3'b000);                       // ignored while stopped
      look("R8 pulse ignored", 4'h4, 32'h0008_0002);
      wr(4'h0, 32'h01);
      // stop and done in the same cycle
      @(posedge clk); #2;
      reg_wr = 1; reg_addr = 4'h0; reg_wdata = 32'h08; done_p = 1;
      @(posedge clk); #2;
      reg_wr = 0; reg_wdata = 0; done_p = 0;
      look("R4 stop beats done", 4'h4, 32'h0008_0002);
      wr(4'h0, 32'h01);
      // status write clearing error while a new error arrives
      @(posedge clk); #2;
      reg_wr = 1; reg_addr = 4'h4; reg_wdata = 32'h2; err_p = 1; cause = 3'b001;
      @(posedge clk); #2;
      reg_wr = 0; reg_wdata = 0; err_p = 0; cause = 0;
      look("R10 set wins", 4'h4, 32'h0002_0002);
      look("R9 read fault", 4'hC, 32'h0001_0000);
      wr(4'h8, 32'h0);
      repeat (8) @(posedge clk);
      @(negedge clk);
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule